// File: doc/BRIEF.md
# Sticky Fault Status Register

This block holds a 16-bit word of latched fault and warning flags for a power-supply monitor. Eleven event inputs arrive as one-cycle pulses from comparator logic elsewhere. Each pulse sets its own flag, and the flag stays set until the host issues a clear. The low byte also carries two derived summary flags. One summarises temperature trouble. The other summarises any non-temperature flag in the high byte. The unused positions always read zero. An active-low notification output tells the host whenever any flag is up.

Flag storage is a bank of sticky cells. A small two-state machine tracks whether the register holds anything, and it drives the notification output. The states are `ST_CLEAN` (no flag held, notification high) and `ST_FAULTED` (at least one flag held, notification low). The transitions are:
- `CLEAN->FAULTED` on any event pulse.
- `FAULTED->CLEAN` on a clear with no event in the same cycle.
- The machine holds its state otherwise.

The full word is readable, and so is the low byte on its own.

Top module: `fault_status_reg`

## Requirements
- R1: After reset the word reads 0000h and `fault_n` is 1.
- R2: An event pulse sets its flag on the next clock edge, at these bit positions:
  - over-temp warning → 14
  - over-temp fault → 13
  - overcurrent warning → 12
  - current fault → 11
  - undervoltage warning → 10
  - undervoltage fault → 9
  - overvoltage warning → 8
  - off → 6
  - overvoltage fault → 5
  - overcurrent fault → 4
  - communication/logic error → 1
- R3: A set flag stays set, without further events, until a clear.
- R4: Bits 15, 7 and 3 always read 0.
- R5: Bit 2 reads 1 exactly when bit 14 or bit 13 is set.
- R6: Bit 0 reads 1 exactly when any of bits 12, 11, 10, 9 or 8 is set.
- R7: A clear pulse with no event zeroes the whole word on the next edge.
- R8: If an event and a clear arrive in the same cycle, the event's flag is set after the edge and all other flags are cleared.
- R9: `fault_n` is 0 exactly when the word is non-zero. It changes on the same edge as the word.
- R10: `status_low` always equals bits 7:0 of `status_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_ot_warn | input | 1 | Over-temperature warning pulse |
| ev_ot_fault | input | 1 | Over-temperature fault pulse |
| ev_oc_warn | input | 1 | Overcurrent warning pulse |
| ev_cur_fault | input | 1 | Current fault pulse |
| ev_uv_warn | input | 1 | Undervoltage warning pulse |
| ev_uv_fault | input | 1 | Undervoltage fault pulse |
| ev_ov_warn | input | 1 | Overvoltage warning pulse |
| ev_off | input | 1 | Output-off pulse |
| ev_ov_fault | input | 1 | Overvoltage fault pulse |
| ev_oc_fault | input | 1 | Overcurrent fault pulse |
| ev_comm_err | input | 1 | Communication/logic error pulse |
| clr_faults | input | 1 | Clear-all pulse |
| status_word | output | 16 | Full status word |
| status_low | output | 8 | Low byte of the status word |
| fault_n | output | 1 | Active-low any-flag notification |

## Verification
The block has no size parameters. The bench builds it with the fixed eleven-event layout and walks all 2048 combinations of simultaneous event pulses. For each combination it checks the latched word, the summary bits, the reserved zeros and `fault_n` against a value computed arithmetically from the bit map. It then holds the pattern idle to confirm stickiness, and then applies a clear together with the bitwise complement of the pattern. This exercises the clear-versus-event priority across every flag pairing.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int NUM_EVT  = 11;
    localparam int WORD_W   = 16;
    localparam int LOW_W    = 8;
    localparam int POS_TEMP = 2;
    localparam int POS_OTHR = 0;

    typedef enum logic {
        ST_CLEAN   = 1'b0,
        ST_FAULTED = 1'b1
    } fsr_state_e;

    // Bit position of each event flag inside the status word.
    function automatic int evt_pos(input int idx);
        case (idx)
            0:       return 14;
            1:       return 13;
            2:       return 12;
            3:       return 11;
            4:       return 10;
            5:       return 9;
            6:       return 8;
            7:       return 6;
            8:       return 5;
            9:       return 4;
            default: return 1;
        endcase
    endfunction
endpackage

// File: rtl/fsr_sticky_bank.sv
module fsr_sticky_bank #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr,
    output logic [N-1:0] held
);
    for (genvar g = 0; g < N; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n)
                held[g] <= 1'b0;
            else if (evt[g])
                held[g] <= 1'b1;
            else if (clr)
                held[g] <= 1'b0;
        end
    end

    // R3: without a clear, no held flag ever drops
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((held & $past(held)) == $past(held)));
endmodule

// File: rtl/fsr_summary.sv
module fsr_summary
    import fsr_pkg::*;
(
    input  logic [NUM_EVT-1:0] held,
    output logic [WORD_W-1:0]  word
);
    always_comb begin
        word = '0;
        for (int i = 0; i < NUM_EVT; i++)
            word[evt_pos(i)] = held[i];
        word[POS_TEMP] = word[14] | word[13];
        word[POS_OTHR] = |word[12:8];
    end
endmodule

// File: rtl/fsr_notify_fsm.sv
module fsr_notify_fsm
    import fsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_evt,
    input  logic clr,
    output logic fault_n
);
    fsr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAN:   if (any_evt) state_d = ST_FAULTED;
            ST_FAULTED: if (clr && !any_evt) state_d = ST_CLEAN;
            default:    state_d = ST_CLEAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        fault_n = (state_q == ST_CLEAN);
    end
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
    import fsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_ot_warn,
    input  logic        ev_ot_fault,
    input  logic        ev_oc_warn,
    input  logic        ev_cur_fault,
    input  logic        ev_uv_warn,
    input  logic        ev_uv_fault,
    input  logic        ev_ov_warn,
    input  logic        ev_off,
    input  logic        ev_ov_fault,
    input  logic        ev_oc_fault,
    input  logic        ev_comm_err,
    input  logic        clr_faults,
    output logic [15:0] status_word,
    output logic [7:0]  status_low,
    output logic        fault_n
);
    logic [NUM_EVT-1:0] evt_vec, held;

    assign evt_vec = {ev_comm_err, ev_oc_fault, ev_ov_fault, ev_off,
                      ev_ov_warn, ev_uv_fault, ev_uv_warn, ev_cur_fault,
                      ev_oc_warn, ev_ot_fault, ev_ot_warn};

    fsr_sticky_bank #(.N(NUM_EVT)) bank_i (
        .clk(clk), .rst_n(rst_n), .evt(evt_vec), .clr(clr_faults), .held(held)
    );

    fsr_summary sum_i (.held(held), .word(status_word));

    fsr_notify_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .any_evt(|evt_vec), .clr(clr_faults),
        .fault_n(fault_n)
    );

    assign status_low = status_word[LOW_W-1:0];

    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[15] | status_word[7] | status_word[3]) == 1'b0);
    assert_ot_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ot_warn |=> status_word[14]);
    assert_comm_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_comm_err |=> status_word[1]);
    assert_temp_summary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ot_fault |=> status_word[2]);
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_faults && evt_vec == '0) |=> status_word == 16'h0000);
    assert_notify_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_n == (status_word == 16'h0000));
endmodule

// File: tb/fault_status_reg_tb.sv
module fault_status_reg_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 0;
    logic rst_n = 0;
    logic [10:0] ev = '0;
    logic clr = 0;
    logic [15:0] status_word;
    logic [7:0]  status_low;
    logic fault_n;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_status_reg dut_i (
        .clk(clk), .rst_n(rst_n),
        .ev_ot_warn(ev[0]), .ev_ot_fault(ev[1]), .ev_oc_warn(ev[2]),
        .ev_cur_fault(ev[3]), .ev_uv_warn(ev[4]), .ev_uv_fault(ev[5]),
        .ev_ov_warn(ev[6]), .ev_off(ev[7]), .ev_ov_fault(ev[8]),
        .ev_oc_fault(ev[9]), .ev_comm_err(ev[10]), .clr_faults(clr),
        .status_word(status_word), .status_low(status_low), .fault_n(fault_n)
    );

    function automatic logic [15:0] expect_word(input logic [10:0] e);
        logic [15:0] w;
        int pos [11] = '{14, 13, 12, 11, 10, 9, 8, 6, 5, 4, 1};
        w = '0;
        for (int i = 0; i < 11; i++)
            if (e[i]) w = w + (16'd1 << pos[i]);
        if (w[14] || w[13]) w = w + 16'd4;
        if ((w & 16'h1F00) != 0) w = w + 16'd1;
        return w;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [10:0] e, input logic c);
        @(negedge clk);
        ev = e;
        clr = c;
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic check_all(input string tag, input logic [15:0] exp);
        chk(tag, status_word, exp);
        chk("R10 low byte", {8'h00, status_low}, {8'h00, exp[7:0]});
        chk("R9 fault_n", {15'h0, fault_n}, {15'h0, exp == 16'h0000});
        chk("R4 reserved", status_word & 16'h8088, 16'h0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        check_all("R1 reset", 16'h0000);
        @(negedge clk);
        rst_n = 1;
        for (int p = 0; p < 2048; p++) begin
            logic [10:0] pat;
            pat = p[10:0];
            step('0, 1'b1);
            check_all("R7 clear", 16'h0000);
            step(pat, 1'b0);
            check_all("R2 R5 R6 set", expect_word(pat));
            step('0, 1'b0);
            check_all("R3 sticky", expect_word(pat));
            step(~pat, 1'b1);
            check_all("R8 event beats clear", expect_word(~pat));
        end
        step('0, 1'b1);
        check_all("R7 final clear", 16'h0000);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule